// File: doc/BRIEF.md
# Indirect register pointer access port

This block gives a host a byte-wide window onto a channel's full register set while occupying only two byte ports. The control port works in two phases. A write in the pointer phase picks a register number. The next control-port access then writes or reads that register, and the pointer drops back to zero. Because of this, a control-port read issued with no pointer set returns the primary status register. The data port reaches the transmit and receive buffers in a single access and leaves the pointer alone.

Register contents are driven out as one flat vector, with a per-register write strobe beside it. The buffers are driven through single-cycle push and pop strobes. The serial engine behind the block supplies the status bytes and the head of the receive buffer.

Top module: `regptr_port`

## Requirements
- R1: While `rst` is high at a clock edge, the pointer returns to 0, the phase returns to pointer phase, and all sixteen write registers clear to 0.
- R2: A `ctl_wr` in pointer phase stores `wdata` into write register 0 and pulses `wr_stb[0]` in that cycle. It sets the pointer to `wdata[3:0]`, so the upper bits are not part of the number, and moves the block into data phase.
- R3: A `ctl_wr` in data phase stores `wdata` into the selected write register and pulses `wr_stb[n]` in that cycle. After the edge the pointer is 0 and the phase is pointer phase. A write register changes only on a `ctl_wr`.
- R4: A `ctl_rd` (with no `ctl_wr`) drives `ctl_rdata` combinationally from the selected read register, then returns the block to pointer 0 in pointer phase. In pointer phase such a read returns read register 0 and leaves the block in pointer phase.
- R5: Read map, by number: 0, 1, 2, 3, 6, 7, 10 and 15 come from `rr_in` byte lanes 0 to 7 in that order; 8 is `rx_data`; 12 and 13 are write registers 12 and 13. Unused numbers mirror a valid one: 4→0, 5→1, 9→13, 11→15, 14→10.
- R6: `dat_wr` raises `tx_push` for that cycle with `tx_byte` = `wdata`. `dat_rd` raises `rx_pop` for that cycle, and `dat_rdata` always equals `rx_data`. Neither changes the pointer or the phase.
- R7: A data-phase `ctl_wr` to register 8 also raises `tx_push`. A data-phase `ctl_rd` of register 8 also raises `rx_pop`. No other control access raises either strobe.
- R8: When a buffer access through the data port and one through the control path fall in the same cycle, they merge into a single one-cycle strobe. The control access still completes its phase step.
- R9: When `ctl_wr` and `ctl_rd` are high together, only the write is performed. The read causes no pop and does not alter the phase step of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_wr | input | 1 | Control-port write strobe |
| ctl_rd | input | 1 | Control-port read strobe |
| dat_wr | input | 1 | Data-port write strobe |
| dat_rd | input | 1 | Data-port read strobe |
| wdata | input | DW | Host write byte |
| ctl_rdata | output | DW | Control-port read value |
| dat_rdata | output | DW | Data-port read value |
| rr_in | input | 8*DW | Status bytes for read registers 0,1,2,3,6,7,10,15 |
| rx_data | input | DW | Head of the receive buffer |
| wr_regs | output | 16*DW | Write register contents, register n at bits n*DW and up |
| wr_stb | output | 16 | Per-register write strobe |
| tx_push | output | 1 | Transmit buffer push strobe |
| tx_byte | output | DW | Byte to push |
| rx_pop | output | 1 | Receive buffer pop strobe |

## Verification
The transmit buffer can be targeted by a data-port write and a control-path write of register 8 in the same cycle. The receive buffer can likewise be targeted by a data-port read and a control read of register 8. The bench sets the pointer to 8 and then asserts both strobes together. It expects exactly one push or pop for that cycle, and it expects the pointer to be back at 0, which it confirms with a following bare read returning register 0. A random phase then mixes all four strobes freely, and a behavioural model judges every cycle.

// File: rtl/regptr_port.sv
module regptr_port #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ctl_wr,
  input  logic            ctl_rd,
  input  logic            dat_wr,
  input  logic            dat_rd,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   ctl_rdata,
  output logic [DW-1:0]   dat_rdata,
  input  logic [8*DW-1:0] rr_in,
  input  logic [DW-1:0]   rx_data,
  output logic [16*DW-1:0] wr_regs,
  output logic [15:0]     wr_stb,
  output logic            tx_push,
  output logic [DW-1:0]   tx_byte,
  output logic            rx_pop
);
  localparam int NW = 16;
  localparam int AW = $clog2(NW);

  logic [AW-1:0] ptr;
  logic          dph;
  logic [DW-1:0] wreg [NW];

  wire rd_act = ctl_rd & ~ctl_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
      dph <= 1'b0;
      for (int i = 0; i < NW; i++) wreg[i] <= '0;
    end else if (ctl_wr) begin
      wreg[ptr] <= wdata;
      ptr <= dph ? '0 : wdata[AW-1:0];
      dph <= ~dph;
    end else if (ctl_rd) begin
      ptr <= '0;
      dph <= 1'b0;
    end
  end

  function automatic logic [DW-1:0] lane(input int k);
    return rr_in[k*DW +: DW];
  endfunction

  always_comb begin
    case (ptr)
      4'd0, 4'd4:   ctl_rdata = lane(0);
      4'd1, 4'd5:   ctl_rdata = lane(1);
      4'd2:         ctl_rdata = lane(2);
      4'd3:         ctl_rdata = lane(3);
      4'd6:         ctl_rdata = lane(4);
      4'd7:         ctl_rdata = lane(5);
      4'd8:         ctl_rdata = rx_data;
      4'd10, 4'd14: ctl_rdata = lane(6);
      4'd12:        ctl_rdata = wreg[12];
      4'd9, 4'd13:  ctl_rdata = wreg[13];
      default:      ctl_rdata = lane(7);
    endcase
  end

  for (genvar g = 0; g < NW; g++) begin : g_out
    assign wr_regs[g*DW +: DW] = wreg[g];
    assign wr_stb[g] = ctl_wr && (ptr == AW'(g));
  end

  assign dat_rdata = rx_data;
  assign tx_byte   = wdata;
  assign tx_push   = dat_wr | (ctl_wr & dph & (ptr == AW'(8)));
  assign rx_pop    = dat_rd | (rd_act & (ptr == AW'(8)));

  p_wr_rest_r3: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && dph) |=> (ptr == '0 && !dph));
  p_rd_rest_r4: assert property (@(posedge clk) disable iff (rst)
    (ctl_rd && !ctl_wr) |=> (ptr == '0 && !dph));
  p_reg_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!ctl_wr && !$past(rst)) |=> $stable(wr_regs));
  p_ptr_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (!ctl_wr && !ctl_rd && !$past(rst)) |=> ($stable(ptr) && $stable(dph)));
  p_push_src_r7: assert property (@(posedge clk) disable iff (rst)
    tx_push |-> (dat_wr || ctl_wr));
  p_pop_src_r9: assert property (@(posedge clk) disable iff (rst)
    rx_pop |-> (dat_rd || (ctl_rd && !ctl_wr)));
  p_stb_one_r2: assert property (@(posedge clk) disable iff (rst)
    $countones(wr_stb) == (ctl_wr ? 1 : 0));
endmodule

// File: tb/sim_regptr_port.sv
module sim_regptr_port;
  localparam int CLK = 10;
  logic clk = 0, rst = 1;
  logic ctl_wr = 0, ctl_rd = 0, dat_wr = 0, dat_rd = 0;
  logic [7:0] wdata = 0, rx_data = 8'h5A;
  logic [63:0] rr_in;
  logic [7:0] ctl_rdata, dat_rdata, tx_byte;
  logic [127:0] wr_regs;
  logic [15:0] wr_stb;
  logic tx_push, rx_pop;
  int total = 0, bad = 0;

  int mp;
  bit mph;
  logic [7:0] wm [16];

  always #(CLK/2) clk = ~clk;

  regptr_port u0 (.clk, .rst, .ctl_wr, .ctl_rd, .dat_wr, .dat_rd, .wdata,
    .ctl_rdata, .dat_rdata, .rr_in, .rx_data, .wr_regs, .wr_stb,
    .tx_push, .tx_byte, .rx_pop);

  task automatic chk(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] ex_rd(int n);
    case (n)
      0, 4:   return rr_in[7:0];
      1, 5:   return rr_in[15:8];
      2:      return rr_in[23:16];
      3:      return rr_in[31:24];
      6:      return rr_in[39:32];
      7:      return rr_in[47:40];
      8:      return rx_data;
      10, 14: return rr_in[55:48];
      12:     return wm[12];
      9, 13:  return wm[13];
      default: return rr_in[63:56];
    endcase
  endfunction

  task automatic step(bit cw, bit cr, bit dw, bit dr, logic [7:0] d);
    bit ep, eq;
    logic [15:0] es;
    @(negedge clk);
    ctl_wr = cw; ctl_rd = cr; dat_wr = dw; dat_rd = dr; wdata = d;
    rx_data = rx_data + 8'd7;
    #1;
    for (int n = 0; n < 16; n++) chk("R3 reg", wr_regs[n*8 +: 8], wm[n]);
    if (!cw && cr) chk("R4 R5 rdata", ctl_rdata, ex_rd(mp));
    chk("R6 dat_rdata", dat_rdata, rx_data);
    es = cw ? (16'd1 << mp) : 16'd0;
    chk("R2 R3 wr_stb", wr_stb, es);
    ep = dw || (cw && mph && mp == 8);
    eq = dr || (cr && !cw && mp == 8);
    chk("R6 R7 R8 tx_push", tx_push, ep);
    chk("R6 R7 R8 R9 rx_pop", rx_pop, eq);
    if (ep) chk("R6 tx_byte", tx_byte, d);
    @(posedge clk);
    if (cw) begin
      wm[mp] = d;
      if (mph) begin mp = 0; mph = 0; end
      else begin mp = d[3:0]; mph = 1; end
    end else if (cr) begin
      mp = 0; mph = 0;
    end
  endtask

  initial begin
    #(CLK*150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 8; k++) rr_in[k*8 +: 8] = 8'hA0 + 8'(k);
    for (int n = 0; n < 16; n++) wm[n] = 0;
    mp = 0; mph = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state: bare read gives register 0, all regs zero
    step(0, 1, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    // R2 R3 writes, upper pointer bits ignored
    step(1, 0, 0, 0, 8'hF5); step(1, 0, 0, 0, 8'h08);
    step(1, 0, 0, 0, 8'h0C); step(1, 0, 0, 0, 8'h34);
    step(1, 0, 0, 0, 8'h3D); step(1, 0, 0, 0, 8'h12);
    step(1, 0, 0, 0, 8'h00); step(1, 0, 0, 0, 8'h66);
    // R4 R5 read every number
    for (int n = 0; n < 16; n++) begin
      step(1, 0, 0, 0, 8'(n));
      step(0, 1, 0, 0, 0);
    end
    // R6 data port leaves pointer alone
    step(1, 0, 0, 0, 8'h06);
    step(0, 0, 1, 0, 8'h77);
    step(0, 0, 0, 1, 0);
    step(0, 1, 0, 0, 0);
    // R7 R8 coincident buffer accesses
    step(1, 0, 0, 0, 8'h08); step(1, 0, 1, 0, 8'h99);
    step(1, 0, 0, 0, 8'h08); step(0, 1, 0, 1, 0);
    step(0, 1, 0, 0, 0);
    step(1, 0, 0, 1, 8'h08); step(0, 1, 0, 0, 0);
    // R9 write and read together
    step(1, 0, 0, 0, 8'h08); step(1, 1, 0, 0, 8'h4E);
    step(1, 1, 0, 0, 8'h02); step(0, 1, 0, 0, 0);
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      int r = $urandom;
      step(r[0] & r[1], r[2], r[3] & r[4], r[5] & r[6], 8'(r >> 8));
    end
    @(negedge clk); rst = 1;
    for (int n = 0; n < 16; n++) wm[n] = 0;
    mp = 0; mph = 0;
    @(negedge clk); rst = 0;
    // R1 reset after traffic
    step(0, 1, 0, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule